// File: doc/BRIEF.md
# Byte-Wide DAC Code and Mode Front End

This block is the digital side of a 12-bit voltage-output converter that hangs on an 8-bit microcontroller bus. The host writes bytes through a two-bit select. One select value fills a low-byte staging register. Another fills a high-nibble staging register. A third loads a three-bit mode register. The fourth select value is unused and changes nothing. A write is taken on the rising edge of the active-low write strobe, and only while the active-low select line is low.

The block turns the staged value into the code that drives the converter. It also produces a fast/slow flag and a power-down flag. Each of these outputs comes from one mode-register bit paired with one board pin, and each pair is combined by its own rule. All strobes and board pins are brought into the system clock domain through a synchronizer chain. Every output is registered.

Top module: `pdac_front`

## Requirements
- R1: After synchronous reset, the staging registers and the mode register hold zero, and the outputs are `dac_code`=0, `fast_mode`=0 and `power_down`=0, provided the pins sit at their idle levels (`we_n`=1, `cs_n`=1, `ldac_n`=1, `spd_pin`=0, `pwr_n_pin`=1).
- R2: A write happens once per 0-to-1 transition of the synchronized `we_n`. It happens only if the synchronized `cs_n` is 0 in that cycle. Writes made while `cs_n` is high change nothing.
- R3: Select `sel`=2'b00 loads all 8 data bits into code bits 7..0. `sel`=2'b01 loads data bits 3..0 into code bits 11..8 and ignores data bits 7..4. `sel`=2'b10 changes nothing.
- R4: `sel`=2'b11 loads the mode register, whose fields are: data bit 0 = speed (1 = fast), bit 1 = sleep (1 = power down), bit 2 = load-through (1 = transparent). Data bits 7..3 are ignored.
- R5: `fast_mode` is 0 only when `spd_pin`=0 and the speed bit is 0. Every other combination gives 1.
- R6: `power_down` is 0 only when `pwr_n_pin`=1 and the sleep bit is 0. Every other combination gives 1.
- R7: `dac_code` keeps its value while the synchronized `ldac_n` is 1 and the load-through bit is 0. Otherwise it reloads the staged 12-bit value on every clock.
- R8: A change on `we_n`, `cs_n`, `ldac_n` or a mode pin takes effect only after the synchronizer chain. The address and data are sampled in the cycle the write is recognised. The outputs follow one register later.
- R9: If `ldac_n` is held low permanently, every staged write appears at `dac_code` without a separate load step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we_n | input | 1 | Active-low write strobe; the data is taken on its rising edge |
| cs_n | input | 1 | Active-low chip select |
| ldac_n | input | 1 | Active-low load pin; low makes the code latch transparent |
| spd_pin | input | 1 | Speed pin, 1 = fast |
| pwr_n_pin | input | 1 | Active-low power pin, 0 = power down |
| sel | input | 2 | Register select |
| data | input | DATA_W | Write data byte |
| dac_code | output | CODE_W | Registered code for the converter |
| fast_mode | output | 1 | 1 = fast settling mode |
| power_down | output | 1 | 1 = converter powered down |

## Verification
The bench uses the default widths: an 8-bit bus, a 12-bit code and a two-stage synchronizer. The latency stays a parameter of the bench, so its reference model delays pin samples by the same depth. With these values the bench can cover all four select codes and the upper-nibble masking. It also drives all four pin/bit combinations of every mode rule. Finally, it issues writes with chip select high and with the strobe held only a few cycles, which exercises the edge detector at its minimum pulse width.

// File: rtl/pdac_pkg.sv
package pdac_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_RSV  = 2'b10,
    SEL_MODE = 2'b11
  } pdac_sel_e;

  // Packed so that speed is bit 0, sleep bit 1, load-through bit 2.
  typedef struct packed {
    logic load_thru;
    logic sleep;
    logic speed;
  } pdac_mode_t;

  localparam int MODE_W = $bits(pdac_mode_t);

endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
  parameter int         WIDTH   = 1,
  parameter int         STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/pdac_reg_bank.sv
module pdac_reg_bank
  import pdac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n_s,
  input  logic              cs_n_s,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] staged,
  output pdac_mode_t        mode_q
);

  localparam int HI_W = CODE_W - DATA_W;

  logic              we_prev;
  logic              wr_stb;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (rst) we_prev <= 1'b1;
    else     we_prev <= we_n_s;
  end

  assign wr_stb = we_n_s & ~we_prev & ~cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
    end else if (wr_stb) begin
      unique case (pdac_sel_e'(sel))
        SEL_LO:   lo_q   <= data;
        SEL_HI:   hi_q   <= data[HI_W-1:0];
        SEL_MODE: mode_q <= data[MODE_W-1:0];
        default:  ;
      endcase
    end
  end

  assign staged = {hi_q, lo_q};

endmodule

// File: rtl/pdac_out_stage.sv
module pdac_out_stage
  import pdac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  pdac_mode_t        mode_q,
  input  logic              ldac_n_s,
  input  logic              spd_s,
  input  logic              pwr_n_s,
  input  logic [CODE_W-1:0] staged,
  output logic [CODE_W-1:0] dac_code,
  output logic              fast_mode,
  output logic              power_down
);

  logic transparent;

  assign transparent = ~ldac_n_s | mode_q.load_thru;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code   <= '0;
      fast_mode  <= 1'b0;
      power_down <= 1'b0;
    end else begin
      if (transparent) dac_code <= staged;
      fast_mode  <= spd_s | mode_q.speed;
      power_down <= ~pwr_n_s | mode_q.sleep;
    end
  end

endmodule

// File: rtl/pdac_front.sv
module pdac_front
  import pdac_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_n,
  input  logic              cs_n,
  input  logic              ldac_n,
  input  logic              spd_pin,
  input  logic              pwr_n_pin,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] dac_code,
  output logic              fast_mode,
  output logic              power_down
);

  localparam int PIN_N = 5;
  // order: we_n, cs_n, ldac_n, spd, pwr_n
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11101;

  logic [PIN_N-1:0]  pins_s;
  logic              we_n_s, cs_n_s, ldac_n_s, spd_s, pwr_n_s;
  logic [CODE_W-1:0] staged;
  pdac_mode_t        mode_q;

  pdac_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({we_n, cs_n, ldac_n, spd_pin, pwr_n_pin}),
    .dout(pins_s)
  );

  assign {we_n_s, cs_n_s, ldac_n_s, spd_s, pwr_n_s} = pins_s;

  pdac_reg_bank #(
    .DATA_W(DATA_W),
    .CODE_W(CODE_W)
  ) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we_n_s(we_n_s),
    .cs_n_s(cs_n_s),
    .sel   (sel),
    .data  (data),
    .staged(staged),
    .mode_q(mode_q)
  );

  pdac_out_stage #(
    .CODE_W(CODE_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .ldac_n_s  (ldac_n_s),
    .spd_s     (spd_s),
    .pwr_n_s   (pwr_n_s),
    .staged    (staged),
    .dac_code  (dac_code),
    .fast_mode (fast_mode),
    .power_down(power_down)
  );

endmodule

// File: rtl/pdac_front_chk.sv
module pdac_front_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_s,
  input logic              ldac_n_s,
  input logic              spd_s,
  input logic              pwr_n_s,
  input logic [2:0]        mode_bits,
  input logic [CODE_W-1:0] staged,
  input logic [CODE_W-1:0] dac_code,
  input logic              fast_mode,
  input logic              power_down
);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (ldac_n_s && !mode_bits[2]) |=> $stable(dac_code));

  a_r7_follow_staged: assert property (@(posedge clk) disable iff (rst)
    (!ldac_n_s || mode_bits[2]) |=> (dac_code == $past(staged)));

  a_r5_slow_only: assert property (@(posedge clk) disable iff (rst)
    (!spd_s && !mode_bits[0]) |=> !fast_mode);

  a_r5_pin_fast: assert property (@(posedge clk) disable iff (rst)
    spd_s |=> fast_mode);

  a_r6_pin_down: assert property (@(posedge clk) disable iff (rst)
    !pwr_n_s |=> power_down);

  a_r6_normal_only: assert property (@(posedge clk) disable iff (rst)
    (pwr_n_s && !mode_bits[1]) |=> !power_down);

  a_r2_cs_blocks: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> ($stable(staged) && $stable(mode_bits)));

endmodule

bind pdac_front pdac_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n_s    (cs_n_s),
  .ldac_n_s  (ldac_n_s),
  .spd_s     (spd_s),
  .pwr_n_s   (pwr_n_s),
  .mode_bits (mode_q),
  .staged    (staged),
  .dac_code  (dac_code),
  .fast_mode (fast_mode),
  .power_down(power_down)
);

// File: tb/pdac_front_bench.sv
module pdac_front_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int CODE_W = 12;
  localparam int SYNC   = 2;

  typedef struct packed {
    logic we, cs, ldac, spd, pwr;
  } pins_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              we_n = 1'b1, cs_n = 1'b1, ldac_n = 1'b1;
  logic              spd_pin = 1'b0, pwr_n_pin = 1'b1;
  logic [1:0]        sel = 2'b00;
  logic [DATA_W-1:0] data = '0;
  logic [CODE_W-1:0] dac_code;
  logic              fast_mode, power_down;

  int checks = 0;
  int failures = 0;
  string phase_req = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdac_front #(.DATA_W(DATA_W), .CODE_W(CODE_W), .SYNC_STAGES(SYNC)) u_pdac_front (
    .clk(clk), .rst(rst), .we_n(we_n), .cs_n(cs_n), .ldac_n(ldac_n),
    .spd_pin(spd_pin), .pwr_n_pin(pwr_n_pin), .sel(sel), .data(data),
    .dac_code(dac_code), .fast_mode(fast_mode), .power_down(power_down)
  );

  // Behavioural reference model
  pins_t             hist[$];
  logic [7:0]        m_lo;
  logic [3:0]        m_hi;
  logic [2:0]        m_mode;
  logic [CODE_W-1:0] m_code;
  logic              m_fast, m_pd;

  always @(posedge clk) begin
    pins_t s, p;
    if (rst) begin
      hist.delete();
      for (int i = 0; i < SYNC + 2; i++) hist.push_back('{1'b1, 1'b1, 1'b1, 1'b0, 1'b1});
      m_lo = '0; m_hi = '0; m_mode = '0; m_code = '0; m_fast = 1'b0; m_pd = 1'b0;
    end else begin
      hist.push_front('{we_n, cs_n, ldac_n, spd_pin, pwr_n_pin});
      void'(hist.pop_back());
      s = hist[SYNC];
      p = hist[SYNC+1];
      if (!s.ldac || m_mode[2]) m_code = {m_hi, m_lo};
      m_fast = s.spd || m_mode[0];
      m_pd   = !s.pwr || m_mode[1];
      if (s.we && !p.we && !s.cs) begin
        case (sel)
          2'b00: m_lo = data;
          2'b01: m_hi = data[3:0];
          2'b11: m_mode = data[2:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check({phase_req, " code"}, dac_code, m_code);
      check({phase_req, " fast"}, fast_mode, m_fast);
      check({phase_req, " pd"},   power_down, m_pd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic csv, input int lowlen);
    @(negedge clk);
    sel = a; data = d; cs_n = csv; we_n = 1'b0;
    cyc(lowlen);
    we_n = 1'b1;
    cyc(4);
    cs_n = 1'b1;
  endtask

  task automatic pulse_ldac;
    @(negedge clk); ldac_n = 1'b0;
    cyc(5);
    ldac_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    cyc(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 code", dac_code, 0);
    check("R1 fast", fast_mode, 0);
    check("R1 pd", power_down, 0);
    cyc(4);

    // R5 speed pin, R6 power pin with mode bits clear
    phase_req = "R5"; spd_pin = 1'b1; cyc(5);
    check("R5 pin fast", fast_mode, 1);
    spd_pin = 1'b0; cyc(5);
    check("R5 slow", fast_mode, 0);
    phase_req = "R6"; pwr_n_pin = 1'b0; cyc(5);
    check("R6 pin down", power_down, 1);
    pwr_n_pin = 1'b1; cyc(5);
    check("R6 normal", power_down, 0);

    // R3 address map, R7 hold
    phase_req = "R3";
    wr(2'b00, 8'hA5, 1'b0, 3);
    wr(2'b01, 8'hF3, 1'b0, 3);
    cyc(3);
    check("R7 held", dac_code, 0);
    pulse_ldac();
    check("R3 hi nibble masked", dac_code, 12'h3A5);
    wr(2'b10, 8'hFF, 1'b0, 3);
    pulse_ldac();
    check("R3 reserved ignored", dac_code, 12'h3A5);
    check("R3 reserved no mode", {fast_mode, power_down}, 0);

    // R2 chip select gating, short strobe
    phase_req = "R2";
    wr(2'b00, 8'h11, 1'b1, 3);
    wr(2'b11, 8'h07, 1'b1, 3);
    pulse_ldac();
    check("R2 cs high ignored", dac_code, 12'h3A5);
    check("R2 cs high mode", {fast_mode, power_down}, 0);
    wr(2'b00, 8'h3C, 1'b0, 1);
    pulse_ldac();
    check("R2 short strobe", dac_code, 12'h33C);

    // R4 mode layout
    phase_req = "R4";
    wr(2'b11, 8'hF8, 1'b0, 3); cyc(3);
    check("R4 upper ignored", {fast_mode, power_down}, 0);
    wr(2'b11, 8'h01, 1'b0, 3); cyc(3);
    check("R4 speed bit", fast_mode, 1);
    check("R4 speed only", power_down, 0);
    wr(2'b11, 8'h02, 1'b0, 3); cyc(3);
    check("R4 sleep bit", power_down, 1);
    check("R5 bit clear slow", fast_mode, 0);
    phase_req = "R6"; pwr_n_pin = 1'b0; cyc(5);
    check("R6 both down", power_down, 1);
    pwr_n_pin = 1'b1; spd_pin = 1'b1;
    phase_req = "R5";
    wr(2'b11, 8'h01, 1'b0, 3); cyc(3);
    check("R5 both fast", fast_mode, 1);
    spd_pin = 1'b0;
    phase_req = "R7";
    wr(2'b11, 8'h04, 1'b0, 3);
    wr(2'b00, 8'h5A, 1'b0, 3); cyc(2);
    check("R7 load bit transparent", dac_code, 12'h35A);
    wr(2'b11, 8'h00, 1'b0, 3);
    wr(2'b01, 8'h09, 1'b0, 3); cyc(3);
    check("R7 hold again", dac_code, 12'h35A);

    // R9 ldac tied low
    phase_req = "R9";
    ldac_n = 1'b0; cyc(3);
    check("R9 immediate", dac_code, 12'h95A);
    wr(2'b00, 8'h00, 1'b0, 3); cyc(1);
    check("R9 immediate lo", dac_code, 12'h900);
    wr(2'b01, 8'h0F, 1'b0, 3); cyc(1);
    check("R9 immediate hi", dac_code, 12'hF00);
    ldac_n = 1'b1;

    // R8 mixed traffic against the cycle model
    phase_req = "R8";
    lf = 32'h1ACE5EED;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      spd_pin   = lf[3];
      pwr_n_pin = lf[4] | lf[9];
      ldac_n    = lf[5] | lf[11];
      wr(lf[7:6], lf[19:12], lf[8] & lf[10], 1 + int'(lf[2]));
    end
    cyc(6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule